// File: doc/BRIEF.md
# Interrupt In-Service and End-of-Service Tracker

This block keeps two bit vectors for a small, fixed set of interrupt sources: which sources have a request waiting, and which are currently being serviced. Its sources are a group of timer channels that behave as one source, two DMA channels and four external interrupt pins. Each source has a 5-bit interrupt type, and priority is fixed: the lowest type number wins. A one-cycle grant strobe moves the best waiting request into service.

A host closes service by writing a 16-bit end-of-service command. With bit 15 set, the command retires the best active service bit, whatever the other bits hold. With bit 15 clear, bits 4:0 name the type whose service bit is retired. All timer channels share one service bit, which type 8 clears. A read-only 16-bit poll word shows whether anything is waiting and the type of the best waiting source. Reading it has no side effects.

When a command write and a grant fall in the same cycle, the write takes effect first and the grant then works on the updated state.

Top module: `isr_tracker`

## Requirements
- R1: After reset, or after reset is asserted at any later point, `inService` and `pollStatus` are all zero.
- R2: A request pulse on any source sets that source's pending bit at the next clock edge. A request on any timer channel sets the single shared timer pending bit. The bit stays set until a grant takes it.
- R3: `pollStatus` bit 15 is 1 when any pending bit is set. Bits 4:0 give the type of the best pending source, and bits 14:5 are zero. When nothing is pending, the word is 0000H. The types are timers 8, DMA0 10, DMA1 11, and external pins 0 to 3 as 12 to 15. A lower type has higher priority.
- R4: A grant sets the `inService` bit of the best pending source and clears its pending bit at the next edge. The bit map is: bit 0 timers, bits 1 and 2 DMA0 and DMA1, bits 3 to 6 external pins 0 to 3. A grant with nothing pending changes nothing.
- R5: A command write with bit 15 = 1 clears the lowest-numbered set `inService` bit. Bits 14:0 are ignored in that case.
- R6: A command write with bit 15 = 0 clears the `inService` bit whose type equals bits 4:0. 0008H clears the shared timer bit, and 000EH clears external pin 2.
- R7: A command write with bit 15 = 0 naming a type that is not in service, or a type no source uses, leaves `inService` unchanged.
- R8: A command write with bit 15 = 1 while no `inService` bit is set leaves `inService` unchanged.
- R9: When a command write and a grant occur in the same cycle, the clear is applied first and the grant second. If both target the same source, its `inService` bit ends set.
- R10: A request that arrives in the same cycle as a grant of that same source leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerReq | input | NUM_TIMERS (3) | Timer channel request pulses |
| dmaReq | input | 2 | DMA channel request pulses |
| extReq | input | 4 | External pin request pulses |
| eoiWrite | input | 1 | End-of-service command write strobe |
| eoiData | input | 16 | End-of-service command word |
| grant | input | 1 | Move the best pending request into service |
| inService | output | 7 | In-service bits per source slot |
| pollStatus | output | 16 | Poll word: bit 15 any-pending, bits 4:0 best type |

## Verification
The end-of-service write and the grant are the two functions that can land in the same cycle. The bench provokes this three ways, each in a single vector that asserts both strobes together:
- a specific clear of the timer bit while a timer request is waiting;
- a nonspecific clear while the grant targets a source that is already in service;
- a grant that coincides with a new request from the source being granted.

Each case is judged by the `inService` vector and the poll word one edge later. When the clear and the grant target the same slot, the bit must end set, because the write is ordered before the grant.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int NUM_DMA    = 2;
  localparam int NUM_EXT    = 4;
  localparam int NUM_SLOTS  = 1 + NUM_DMA + NUM_EXT;
  localparam int TYPE_W     = 5;
  localparam int CMD_W      = 16;
  localparam int NSPEC_BIT  = 15;
  localparam int TIMER_TYPE = 8;
  localparam int DMA_BASE   = 10;
  localparam int EXT_BASE   = 12;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] eoiClr;
    logic [NUM_SLOTS-1:0] grantSet;
  } ctrlStrobes_t;

  // Slot 0 is the timer group, followed by the DMA slots, then the external pins.
  function automatic logic [TYPE_W-1:0] slotType(input int slot);
    if (slot == 0)
      return TYPE_W'(TIMER_TYPE);
    else if (slot <= NUM_DMA)
      return TYPE_W'(DMA_BASE + slot - 1);
    else
      return TYPE_W'(EXT_BASE + slot - 1 - NUM_DMA);
  endfunction
endpackage

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
  parameter int W  = 7,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic [W-1:0]  oneHot,
  output logic [IW-1:0] idx,
  output logic          any
);
  // The lowest index wins: the loop runs downward so that it overwrites last.
  always_comb begin
    oneHot = '0;
    idx    = '0;
    any    = |req;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        oneHot    = '0;
        oneHot[i] = 1'b1;
        idx       = IW'(i);
      end
    end
  end
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 eoiWrite,
  input  logic [CMD_W-1:0]     eoiData,
  input  logic                 grant,
  input  logic [NUM_SLOTS-1:0] pend,
  input  logic [NUM_SLOTS-1:0] inSvc,
  output ctrlStrobes_t         strobes
);
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] svcHigh;
  logic [NUM_SLOTS-1:0] pendHigh;
  logic [NUM_SLOTS-1:0] typeMatch;
  logic [IW-1:0]        svcIdx;
  logic [IW-1:0]        pendIdx;
  logic                 svcAny;
  logic                 pendAny;
  logic                 unusedCtrl;

  assign unusedCtrl = ^{svcIdx, pendIdx, svcAny, eoiData[NSPEC_BIT-1:TYPE_W]};

  isr_prio_pick #(.W(NUM_SLOTS)) uSvcPick (
    .req(inSvc), .oneHot(svcHigh), .idx(svcIdx), .any(svcAny)
  );

  isr_prio_pick #(.W(NUM_SLOTS)) uPendPick (
    .req(pend), .oneHot(pendHigh), .idx(pendIdx), .any(pendAny)
  );

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++)
      typeMatch[s] = (eoiData[TYPE_W-1:0] == slotType(s));
  end

  always_comb begin
    strobes.eoiClr = '0;
    if (eoiWrite) begin
      if (eoiData[NSPEC_BIT])
        strobes.eoiClr = svcHigh;
      else
        strobes.eoiClr = typeMatch & inSvc;
    end
    strobes.grantSet = (grant && pendAny) ? pendHigh : '0;
  end

  // R5: a nonspecific command retires at most one service bit.
  a_r5_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.eoiClr));

  // R4: a grant moves at most one source.
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.grantSet));

  // R6: a specific clear touches only a bit that is in service.
  a_r6_clear_in_service: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eoiClr & ~inSvc) == '0);
endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TIMERS-1:0] timerReq,
  input  logic [NUM_DMA-1:0]    dmaReq,
  input  logic [NUM_EXT-1:0]    extReq,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_SLOTS-1:0]  pend,
  output logic [NUM_SLOTS-1:0]  inSvc,
  output logic [CMD_W-1:0]      pollStatus
);
  localparam int IW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int DMA_LO   = 1;
  localparam int EXT_LO   = 1 + NUM_DMA;
  localparam int RSV_W    = CMD_W - 1 - TYPE_W;

  logic [NUM_SLOTS-1:0] reqVec;
  logic [NUM_SLOTS-1:0] pollOneHot;
  logic [IW-1:0]        pollIdx;
  logic                 pollAny;
  logic                 unusedDp;

  assign unusedDp = ^pollOneHot;

  always_comb begin
    reqVec = '0;
    reqVec[0] = |timerReq;
    reqVec[DMA_LO +: NUM_DMA] = dmaReq;
    reqVec[EXT_LO +: NUM_EXT] = extReq;
  end

  // The clear is ordered before the set, so a grant wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend  <= '0;
      inSvc <= '0;
    end else begin
      pend  <= (pend & ~strobes.grantSet) | reqVec;
      inSvc <= (inSvc & ~strobes.eoiClr) | strobes.grantSet;
    end
  end

  isr_prio_pick #(.W(NUM_SLOTS)) uPollPick (
    .req(pend), .oneHot(pollOneHot), .idx(pollIdx), .any(pollAny)
  );

  always_comb begin
    pollStatus = '0;
    if (pollAny)
      pollStatus = {1'b1, {RSV_W{1'b0}}, slotType(int'(pollIdx))};
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (inSvc == '0 && pend == '0));

  a_r4_grant_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grantSet != '0) |=> ((inSvc & $past(strobes.grantSet)) != '0));

  // R10: a granted slot drops pending unless a fresh request came with it.
  a_r10_pend_retire: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grantSet != '0) |=> ((pend & $past(strobes.grantSet & ~reqVec)) == '0));

  a_r9_grant_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.grantSet & strobes.eoiClr) != '0) |=>
      ((inSvc & $past(strobes.grantSet)) != '0));

  a_r3_poll_range: assert property (@(posedge clk) disable iff (!rstN)
    pollStatus[CMD_W-1] |-> (pollStatus[TYPE_W-1:0] >= TYPE_W'(TIMER_TYPE)));

  a_r2_request_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec != '0) |=> pollStatus[CMD_W-1]);
endmodule

// File: rtl/isr_tracker.sv
module isr_tracker
  import isr_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TIMERS-1:0] timerReq,
  input  logic [1:0]            dmaReq,
  input  logic [3:0]            extReq,
  input  logic                  eoiWrite,
  input  logic [15:0]           eoiData,
  input  logic                  grant,
  output logic [6:0]            inService,
  output logic [15:0]           pollStatus
);
  ctrlStrobes_t         strobes;
  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_SLOTS-1:0] inSvc;

  isr_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .eoiWrite(eoiWrite), .eoiData(eoiData), .grant(grant),
    .pend(pend), .inSvc(inSvc), .strobes(strobes)
  );

  isr_datapath #(.NUM_TIMERS(NUM_TIMERS)) uDp (
    .clk(clk), .rstN(rstN),
    .timerReq(timerReq), .dmaReq(dmaReq), .extReq(extReq),
    .strobes(strobes), .pend(pend), .inSvc(inSvc), .pollStatus(pollStatus)
  );

  assign inService = inSvc;

  a_r8_empty_nonspec: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWrite && eoiData[15] && inService == '0 && !grant) |=> (inService == '0));

  a_r7_unused_type: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWrite && !eoiData[15] && (eoiData[4:0] < 5'd8 || eoiData[4:0] == 5'd9 ||
      eoiData[4:0] > 5'd15) && !grant) |=> $stable(inService));
endmodule

// File: tb/sim_isr_tracker.sv
`timescale 1ns/1ps
module sim_isr_tracker;
  typedef struct packed {
    logic [2:0]  tmr;
    logic [1:0]  dma;
    logic [3:0]  ext;
    logic        wr;
    logic [15:0] data;
    logic        gnt;
    logic [6:0]  expIs;
    logic [15:0] expPoll;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 2'b00, 4'b0100, 1'b0, 16'h0000, 1'b0, 7'b0000000, 16'h800E, 4'd2},  // R2 ext2
    '{3'b000, 2'b10, 4'b0000, 1'b0, 16'h0000, 1'b0, 7'b0000000, 16'h800B, 4'd3},  // R3 dma1 beats ext2
    '{3'b000, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b1, 7'b0000100, 16'h800E, 4'd4},  // R4 grant dma1
    '{3'b010, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b0, 7'b0000100, 16'h8008, 4'd3},  // R3 timer
    '{3'b000, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b1, 7'b0000101, 16'h800E, 4'd4},  // R4 grant timer
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h8000, 1'b0, 7'b0000100, 16'h800E, 4'd5},  // R5 nonspecific
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h000C, 1'b0, 7'b0000100, 16'h800E, 4'd7},  // R7 not in service
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h0013, 1'b0, 7'b0000100, 16'h800E, 4'd7},  // R7 unused type
    '{3'b000, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b1, 7'b0100100, 16'h0000, 4'd4},  // R4 grant ext2
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h000E, 1'b0, 7'b0000100, 16'h0000, 4'd6},  // R6 clear ext2
    '{3'b000, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b1, 7'b0000100, 16'h0000, 4'd4},  // R4 empty grant
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h800B, 1'b0, 7'b0000000, 16'h0000, 4'd5},  // R5 low bits ignored
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h8000, 1'b0, 7'b0000000, 16'h0000, 4'd8},  // R8 empty nonspecific
    '{3'b101, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b0, 7'b0000000, 16'h8008, 4'd2},  // R2 two timers
    '{3'b000, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b1, 7'b0000001, 16'h0000, 4'd4},  // R4
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h0008, 1'b0, 7'b0000000, 16'h0000, 4'd6},  // R6 timer type 8
    '{3'b001, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b0, 7'b0000000, 16'h8008, 4'd2},  // R2
    '{3'b000, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b1, 7'b0000001, 16'h0000, 4'd4},  // R4
    '{3'b100, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b0, 7'b0000001, 16'h8008, 4'd2},  // R2
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h0008, 1'b1, 7'b0000001, 16'h0000, 4'd9},  // R9 same slot
    '{3'b000, 2'b00, 4'b1000, 1'b0, 16'h0000, 1'b0, 7'b0000001, 16'h800F, 4'd2},  // R2 ext3
    '{3'b000, 2'b00, 4'b1000, 1'b0, 16'h0000, 1'b1, 7'b1000001, 16'h800F, 4'd10}, // R10 re-request
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h8000, 1'b1, 7'b1000000, 16'h0000, 4'd9},  // R9 clear then grant
    '{3'b000, 2'b01, 4'b0010, 1'b0, 16'h0000, 1'b0, 7'b1000000, 16'h800A, 4'd3},  // R3 dma0 beats ext1
    '{3'b000, 2'b00, 4'b0000, 1'b1, 16'h000F, 1'b0, 7'b0000000, 16'h800A, 4'd6},  // R6 clear ext3
    '{3'b000, 2'b00, 4'b0000, 1'b0, 16'h0000, 1'b1, 7'b0000010, 16'h800D, 4'd4}   // R4 grant dma0
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  timerReq = '0;
  logic [1:0]  dmaReq = '0;
  logic [3:0]  extReq = '0;
  logic        eoiWrite = 1'b0;
  logic [15:0] eoiData = '0;
  logic        grant = 1'b0;
  logic [6:0]  inService;
  logic [15:0] pollStatus;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  isr_tracker #(.NUM_TIMERS(3)) u0 (
    .clk(clk), .rstN(rstN), .timerReq(timerReq), .dmaReq(dmaReq), .extReq(extReq),
    .eoiWrite(eoiWrite), .eoiData(eoiData), .grant(grant),
    .inService(inService), .pollStatus(pollStatus)
  );

  task automatic check(input int req, input logic [6:0] expIs, input logic [15:0] expPoll);
    checks++;
    if (inService !== expIs) begin
      errors++;
      $display("FAIL R%0d inService actual=%b expected=%b", req, inService, expIs);
    end
    checks++;
    if (pollStatus !== expPoll) begin
      errors++;
      $display("FAIL R%0d pollStatus actual=%h expected=%h", req, pollStatus, expPoll);
    end
  endtask

  task automatic idle();
    timerReq = '0; dmaReq = '0; extReq = '0;
    eoiWrite = 1'b0; eoiData = '0; grant = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 7'd0, 16'h0000);  // R1 state held in reset
    rstN = 1'b1;
    @(negedge clk);
    check(1, 7'd0, 16'h0000);  // R1 after release
    for (int i = 0; i < NV; i++) begin
      timerReq = VECS[i].tmr;
      dmaReq   = VECS[i].dma;
      extReq   = VECS[i].ext;
      eoiWrite = VECS[i].wr;
      eoiData  = VECS[i].data;
      grant    = VECS[i].gnt;
      @(negedge clk);
      idle();
      check(int'(VECS[i].req), VECS[i].expIs, VECS[i].expPoll);
    end
    // R1: a reset in the middle of a run clears both service and pending state
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 7'd0, 16'h0000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule